// File: doc/BRIEF.md
# I2C Slave Address Match Status Flags

This block keeps the sticky status flags that an I2C/SMBus slave raises once it has recognised an address on the bus. The address comparator upstream reports each kind of hit as a single-cycle strobe: the first slave address, the second slave address, the SMBus default device address and the SMBus host header. The block latches these hits into a 16-bit read-only status word. The word also shows the running packet-error-check byte that a separate CRC unit computes.

The address-resolution enable and the host-type select gate the flags. A flag stays set until the bus detector reports a stop or a repeated start, or until the peripheral is disabled. Bit 7 tells the reader which of the two slave addresses was last matched.

Top module: `i2c_slv_match_flags`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, status bits 7:5 read 0.
- R2: A cycle with `stop_det`=1, `rstart_det`=1 or `periph_en`=0 leaves status bits 7:5 at 0 after the next rising clock edge. This holds even when match strobes arrive in that same cycle.
- R3: Status bit 5 is set by a `hit_default` strobe only while `arp_en`=1. The strobe has no effect on bit 5 when `arp_en`=0.
- R4: Status bit 6 is set by a `hit_host` strobe only while both `arp_en`=1 and `host_sel`=1. In every other case the strobe has no effect on bit 6.
- R5: When no clear condition is present, a `hit_secondary` strobe makes status bit 7 read 1 after the next edge, and a `hit_primary` strobe makes it read 0. If both strobes arrive in the same cycle, the secondary strobe wins.
- R6: With no clear condition and no qualifying strobe, status bits 7:5 keep their values.
- R7: Status bits 15:8 follow `pec_val` combinationally while `pec_en`=1 and read 0 while `pec_en`=0.
- R8: Status bits 4:0 always read 0. The block has no write path, so no bit of the word can be changed from outside except through the inputs above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; low clears the flags |
| arp_en | input | 1 | SMBus address-resolution mode enable |
| host_sel | input | 1 | SMBus host-type select |
| pec_en | input | 1 | Packet-error-check enable |
| hit_primary | input | 1 | Strobe: first slave address matched |
| hit_secondary | input | 1 | Strobe: second slave address matched |
| hit_default | input | 1 | Strobe: SMBus default device address received |
| hit_host | input | 1 | Strobe: SMBus host header received |
| stop_det | input | 1 | Strobe: stop condition detected |
| rstart_det | input | 1 | Strobe: repeated start detected |
| pec_val | input | PEC_W | Current packet-error-check value from the CRC unit |
| status | output | 16 | Read-only status word |

## Verification
The hardest cases to reach are the collisions. In one, a set strobe meets a clear condition in the same cycle while the flag is already set. In another, both address strobes arrive together while bit 7 holds the opposite value. Reaching either needs a particular earlier state followed by a particular input combination.

The bench sweeps every combination of the ten control inputs twice. The first pass runs in counting order and the second in a scrambled order, so each combination is met from many different flag states. A reference model built from the requirements predicts every resulting word.

// File: rtl/i2c_slv_match_flags.sv
module i2c_slv_match_flags #(
  parameter int PEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             periph_en,
  input  logic             arp_en,
  input  logic             host_sel,
  input  logic             pec_en,
  input  logic             hit_primary,
  input  logic             hit_secondary,
  input  logic             hit_default,
  input  logic             hit_host,
  input  logic             stop_det,
  input  logic             rstart_det,
  input  logic [PEC_W-1:0] pec_val,
  output logic [15:0]      status
);

  localparam int PEC_LSB = 8;
  localparam int PAD_W   = 16 - PEC_LSB - PEC_W;

  logic flush;
  logic dflt_q, host_q, sec_q;

  assign flush = stop_det | rstart_det | ~periph_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dflt_q <= 1'b0;
      host_q <= 1'b0;
      sec_q  <= 1'b0;
    end else if (flush) begin
      dflt_q <= 1'b0;
      host_q <= 1'b0;
      sec_q  <= 1'b0;
    end else begin
      if (hit_default && arp_en)             dflt_q <= 1'b1;
      if (hit_host && arp_en && host_sel)    host_q <= 1'b1;
      if (hit_secondary)                     sec_q  <= 1'b1;
      else if (hit_primary)                  sec_q  <= 1'b0;
    end
  end

  logic [PEC_W-1:0] pec_shown;
  assign pec_shown = pec_en ? pec_val : '0;

  generate
    if (PAD_W > 0) begin : g_pad
      assign status[15 -: PAD_W] = '0;
    end
  endgenerate

  assign status[PEC_LSB +: PEC_W] = pec_shown;
  assign status[7:5] = {sec_q, host_q, dflt_q};
  assign status[4:0] = 5'b0;

  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> status[7:5] == 3'b000);

  // R3
  dflt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> $past(hit_default && arp_en));

  // R4
  host_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(hit_host && arp_en && host_sel));

  // R5
  sec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && hit_secondary) |=> status[7]);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !hit_default && !hit_host && !hit_secondary && !hit_primary)
      |=> $stable(status[7:5]));

endmodule

// File: tb/tb_i2c_slv_match_flags.sv
module tb_i2c_slv_match_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periph_en = 0, arp_en = 0, host_sel = 0, pec_en = 0;
  logic hit_primary = 0, hit_secondary = 0, hit_default = 0, hit_host = 0;
  logic stop_det = 0, rstart_det = 0;
  logic [7:0] pec_val = 8'h00;
  logic [15:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic e5 = 0, e6 = 0, e7 = 0;

  always #2 clk = ~clk;

  i2c_slv_match_flags #(.PEC_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .arp_en(arp_en),
    .host_sel(host_sel), .pec_en(pec_en), .hit_primary(hit_primary),
    .hit_secondary(hit_secondary), .hit_default(hit_default),
    .hit_host(hit_host), .stop_det(stop_det), .rstart_det(rstart_det),
    .pec_val(pec_val), .status(status)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: status=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input int v, input int p);
    logic clr;
    logic [15:0] w;
    {periph_en, arp_en, host_sel, pec_en, hit_primary, hit_secondary,
     hit_default, hit_host, stop_det, rstart_det} = v[9:0];
    pec_val = p[7:0];
    clr = stop_det | rstart_det | ~periph_en;
    if (clr) begin
      e5 = 0; e6 = 0; e7 = 0;
    end else begin
      if (hit_default && arp_en) e5 = 1;
      if (hit_host && arp_en && host_sel) e6 = 1;
      if (hit_secondary) e7 = 1;
      else if (hit_primary) e7 = 0;
    end
    @(negedge clk);
    w = {(pec_en ? p[7:0] : 8'h00), e7, e6, e5, 5'b00000};
    if (clr) check("R2", status, w);
    else if (hit_default || hit_host) check("R3/R4", status, w);
    else if (hit_primary || hit_secondary) check("R5", status, w);
    else check("R6", status, w);
    check("R7", {8'h00, status[15:8]}, {8'h00, (pec_en ? p[7:0] : 8'h00)});
    check("R8", {11'h0, status[4:0]}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", status & 16'h00E0, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 1024; i++) apply(i, i * 7 + 3);
    for (int i = 0; i < 1024; i++) apply((i * 389 + 77) % 1024, i * 13);
    // R3 directed: default hit without arp has no effect
    apply(10'b1000001000, 8'h5A);
    apply(10'b1000001000, 8'h5A);
    // R4 directed: host hit with arp only
    apply(10'b1100000100, 8'h00);
    // R5 directed: both address strobes together -> secondary
    apply(10'b1000100000, 8'h00);
    apply(10'b1000110000, 8'h00);
    // R2 directed: set and clear together
    apply(10'b1111001110, 8'hC3);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule